// File: doc/BRIEF.md
# Crosspoint Connection Matrix Controller

This block keeps the connection state of a square crosspoint array and changes it in response to decoded configuration commands. Each command is a 4-bit opcode with a 7-bit operand, and it arrives with a valid strobe that lasts one cycle. An input address register selects the input row. Commands can load that register, join or break a single cell, clear the whole array, or write a single mode bit. The three connect variants differ in which existing cells they break. One of them also advances the input address by one, so a stream of connect commands can configure successive inputs.

The block drives the complete connection matrix. It also gives, for each output column, a valid flag and the index of the input selected for that column. A switching datapath can use this view directly. A fixed 32-bit identification word is driven on a separate output.

Top module: `xbar_matrix_ctrl`

## Requirements
- R1: Opcode 0x1 copies the 7-bit operand into the input address register.
- R2: Opcode 0x2 clears only the cell at (input = address register, output = operand). Every other cell keeps its value.
- R3: Opcode 0x3 sets the target cell. It clears every other cell in the same input row and every other cell in the same output column.
- R4: Opcode 0x3 increments the input address register by one, modulo 128. This also happens when the target is out of range.
- R5: Opcode 0x4 sets the target cell and clears the other cells of its output column. The rest of the input row is unchanged.
- R6: Opcode 0x5 clears every cell. The address register and the mode bit are unchanged.
- R7: Opcode 0x6 writes operand bit 0 into the mode bit. No other state changes.
- R8: Opcodes 0x0, 0x7 to 0xF, and cycles without valid, leave the matrix, the address register and the mode bit unchanged.
- R9: A connect or disconnect command is ignored when its input or output address is N or greater. Addresses are compared in full 7-bit width, with no wrap.
- R10: Matrix bit out*N+in holds cell (in, out). For each output, outValid is high when any input is connected, and outSel gives that input's index. No column ever holds more than one set cell.
- R11: A synchronous active-high rst clears the matrix, the address register and the mode bit.
- R12: devId always reads 0x0000C89F.
- R13: A command takes effect on the rising edge where cmdValid is high and is visible on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 4 | Command opcode |
| cmdArg | input | 7 | Command operand |
| connMatrix | output | N*N | Cell state, bit out*N+in |
| outValid | output | N | Output has a connected input |
| outSel | output | N*$clog2(N) | Selected input per output, field out |
| addrReg | output | 7 | Input address register |
| modeBit | output | 1 | Mode control bit |
| devId | output | 32 | Identification constant |

## Verification
The matrix, the address register and the mode bit are each one register stage after the command edge. outValid and outSel are decoded combinationally from the matrix, so all results are due on the first edge that samples the command. The bench drives each command on a falling edge and holds it for one cycle. It samples every output on the next falling edge, half a period after the update, so no check depends on the order in which processes run at the edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int ADDR_W = 7;
  localparam int OP_W = 4;
  localparam logic [31:0] DEV_ID = 32'h0000C89F;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'h0,
    OP_LDADDR  = 4'h1,
    OP_DISC    = 4'h2,
    OP_CONFULL = 4'h3,
    OP_CONOUT  = 4'h4,
    OP_CLRALL  = 4'h5,
    OP_SETMODE = 4'h6,
    OP_IDENT   = 4'h7,
    OP_BYPASS  = 4'hF
  } opcode_e;

  // strobes from control to cell storage
  typedef struct packed {
    logic              clrAll;
    logic              setCell;
    logic              clrCell;
    logic              clrRow;
    logic              clrCol;
    logic [ADDR_W-1:0] row;
    logic [ADDR_W-1:0] col;
  } cellCmd_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [ADDR_W-1:0] cmdArg,
  output cellCmd_t          cellCmd,
  output logic [ADDR_W-1:0] addrReg,
  output logic              modeBit
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(N);

  logic inRange;
  opcode_e opc;

  assign opc = opcode_e'(cmdOp);
  assign inRange = ({1'b0, addrReg} < LIMIT) && ({1'b0, cmdArg} < LIMIT);

  always_comb begin
    cellCmd = '0;
    cellCmd.row = addrReg;
    cellCmd.col = cmdArg;
    if (cmdValid) begin
      case (opc)
        OP_DISC:    cellCmd.clrCell = inRange;
        OP_CONFULL: begin
          cellCmd.setCell = inRange;
          cellCmd.clrRow  = inRange;
          cellCmd.clrCol  = inRange;
        end
        OP_CONOUT:  begin
          cellCmd.setCell = inRange;
          cellCmd.clrCol  = inRange;
        end
        OP_CLRALL:  cellCmd.clrAll = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      modeBit <= 1'b0;
    end else if (cmdValid) begin
      case (opc)
        OP_LDADDR:  addrReg <= cmdArg;
        OP_CONFULL: addrReg <= addrReg + 1'b1;
        OP_SETMODE: modeBit <= cmdArg[0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/xbar_array.sv
module xbar_array
  import xbar_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cellCmd_t          cellCmd,
  output logic [N*N-1:0]    connMatrix,
  output logic [N-1:0]      outValid,
  output logic [N*$clog2(N)-1:0] outSel
);
  localparam int IW = $clog2(N);

  for (genvar c = 0; c < N; c++) begin : g_col
    logic hitCol;
    assign hitCol = (cellCmd.col == ADDR_W'(c));

    for (genvar r = 0; r < N; r++) begin : g_row
      logic hitRow;
      assign hitRow = (cellCmd.row == ADDR_W'(r));
      always_ff @(posedge clk) begin
        if (rst || cellCmd.clrAll)
          connMatrix[c*N+r] <= 1'b0;
        else if (cellCmd.setCell && hitCol && hitRow)
          connMatrix[c*N+r] <= 1'b1;
        else if ((cellCmd.clrCell && hitCol && hitRow) ||
                 (cellCmd.clrCol && hitCol) ||
                 (cellCmd.clrRow && hitRow))
          connMatrix[c*N+r] <= 1'b0;
      end
    end

    logic [IW-1:0] selIdx;
    always_comb begin
      selIdx = '0;
      for (int r = 0; r < N; r++)
        if (connMatrix[c*N+r]) selIdx = IW'(r);
    end
    assign outSel[c*IW +: IW] = selIdx;
    assign outValid[c] = |connMatrix[c*N +: N];
  end
endmodule

// File: rtl/xbar_matrix_ctrl.sv
module xbar_matrix_ctrl
  import xbar_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [6:0]        cmdArg,
  output logic [N*N-1:0]    connMatrix,
  output logic [N-1:0]      outValid,
  output logic [N*$clog2(N)-1:0] outSel,
  output logic [6:0]        addrReg,
  output logic              modeBit,
  output logic [31:0]       devId
);
  cellCmd_t cellCmd;

  assign devId = DEV_ID;

  xbar_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .cellCmd(cellCmd), .addrReg(addrReg), .modeBit(modeBit)
  );

  xbar_array #(.N(N)) u_array (
    .clk(clk), .rst(rst), .cellCmd(cellCmd),
    .connMatrix(connMatrix), .outValid(outValid), .outSel(outSel)
  );
endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           cmdValid,
  input logic [3:0]     cmdOp,
  input logic [6:0]     cmdArg,
  input logic [N*N-1:0] connMatrix,
  input logic [6:0]     addrReg,
  input logic           modeBit
);
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 4'h1) |=> addrReg == $past(cmdArg)); // R1

  AST_FULL_INC: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 4'h3) |=> addrReg == 7'($past(addrReg) + 7'd1)); // R4

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 4'h5) |=> (connMatrix == '0 && $stable(addrReg) && $stable(modeBit))); // R6

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 4'h6) |=> (modeBit == $past(cmdArg[0]) && $stable(connMatrix))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdOp == 4'h0 || cmdOp >= 4'h7) |=>
      ($stable(connMatrix) && $stable(addrReg) && $stable(modeBit))); // R8

  for (genvar c = 0; c < N; c++) begin : g_colchk
    AST_COL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(connMatrix[c*N +: N])); // R10
  end
endmodule

bind xbar_matrix_ctrl xbar_matrix_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
  .connMatrix(connMatrix), .addrReg(addrReg), .modeBit(modeBit)
);

// File: tb/xbar_matrix_ctrl_bench.sv
`timescale 1ns/1ps
module xbar_matrix_ctrl_bench;
  localparam int N = 16;
  localparam int IW = 4;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [6:0] cmdArg = '0;
  logic [N*N-1:0] connMatrix;
  logic [N-1:0] outValid;
  logic [N*IW-1:0] outSel;
  logic [6:0] addrReg;
  logic modeBit;
  logic [31:0] devId;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xbar_matrix_ctrl #(.N(N)) u_xbar_matrix_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .connMatrix(connMatrix), .outValid(outValid), .outSel(outSel),
    .addrReg(addrReg), .modeBit(modeBit), .devId(devId)
  );

  // {op[31:28], arg[27:21], expAddr[20:14], expMode[13], probe[12:9], expValid[8], expSel[7:4], req[3:0]}
  localparam logic [31:0] VEC [NV] = '{
    {4'h1, 7'd3,   7'd3,   1'b0, 4'd5, 1'b0, 4'd0, 4'd1},  // R1 load
    {4'h3, 7'd5,   7'd4,   1'b0, 4'd5, 1'b1, 4'd3, 4'd3},  // R3 full connect
    {4'h4, 7'd5,   7'd4,   1'b0, 4'd5, 1'b1, 4'd4, 4'd5},  // R5 column takeover
    {4'h4, 7'd7,   7'd4,   1'b0, 4'd7, 1'b1, 4'd4, 4'd5},  // R5 second output same row
    {4'h1, 7'd4,   7'd4,   1'b0, 4'd5, 1'b1, 4'd4, 4'd5},  // R5 row kept
    {4'h2, 7'd7,   7'd4,   1'b0, 4'd7, 1'b0, 4'd0, 4'd2},  // R2 disconnect
    {4'hF, 7'd0,   7'd4,   1'b0, 4'd5, 1'b1, 4'd4, 4'd2},  // R2 neighbour untouched
    {4'h3, 7'd9,   7'd5,   1'b0, 4'd5, 1'b0, 4'd0, 4'd3},  // R3 row cleared
    {4'h7, 7'd9,   7'd5,   1'b0, 4'd9, 1'b1, 4'd4, 4'd8},  // R8 identify inert
    {4'h6, 7'd1,   7'd5,   1'b1, 4'd9, 1'b1, 4'd4, 4'd7},  // R7 mode on
    {4'h6, 7'd2,   7'd5,   1'b0, 4'd9, 1'b1, 4'd4, 4'd7},  // R7 bit0 only
    {4'h6, 7'h7F,  7'd5,   1'b1, 4'd9, 1'b1, 4'd4, 4'd7},  // R7 mode on again
    {4'h1, 7'd20,  7'd20,  1'b1, 4'd9, 1'b1, 4'd4, 4'd1},  // R1 out-of-range input
    {4'h3, 7'd2,   7'd21,  1'b1, 4'd2, 1'b0, 4'd0, 4'd9},  // R9 ignored, R4 still inc
    {4'h1, 7'd2,   7'd2,   1'b1, 4'd9, 1'b1, 4'd4, 4'd1},  // R1
    {4'h4, 7'd16,  7'd2,   1'b1, 4'd0, 1'b0, 4'd0, 4'd9},  // R9 output 16 no wrap
    {4'h2, 7'd9,   7'd2,   1'b1, 4'd9, 1'b1, 4'd4, 4'd2},  // R2 other row kept
    {4'h5, 7'd0,   7'd2,   1'b1, 4'd9, 1'b0, 4'd0, 4'd6},  // R6 clear all
    {4'h8, 7'd3,   7'd2,   1'b1, 4'd9, 1'b0, 4'd0, 4'd8},  // R8 unlisted
    {4'h1, 7'd127, 7'd127, 1'b1, 4'd0, 1'b0, 4'd0, 4'd1},  // R1 top address
    {4'h3, 7'd0,   7'd0,   1'b1, 4'd0, 1'b0, 4'd0, 4'd4},  // R4 wrap
    {4'h3, 7'd1,   7'd1,   1'b1, 4'd1, 1'b1, 4'd0, 4'd10}, // R10 select view
    {4'h0, 7'd1,   7'd1,   1'b1, 4'd1, 1'b1, 4'd0, 4'd8}   // R8 opcode 0
  };

  task automatic check(input bit ok, input string req, input logic [N*N-1:0] act,
                       input logic [N*N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [3:0] op, input logic [6:0] arg);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0; cmdArg = '0;
  endtask

  task automatic colCheck();
    bit ok = 1;
    for (int c = 0; c < N; c++)
      if ($countones(connMatrix[c*N +: N]) > 1) ok = 0;
    check(ok, "R10 column single", connMatrix, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(connMatrix == '0, "R11 matrix", connMatrix, '0);
    check(addrReg == 7'd0, "R11 addr", addrReg, 0);
    check(modeBit == 1'b0, "R11 mode", modeBit, 0);
    check(outValid == '0, "R11 outValid", outValid, 0);
    check(devId == 32'h0000C89F, "R12 id", devId, 32'h0000C89F);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      logic [3:0] p;
      v = VEC[i];
      p = v[12:9];
      sendCmd(v[31:28], v[27:21]);
      // R13 result visible one edge after command
      check(addrReg == v[20:14], $sformatf("R%0d vec%0d addr", v[3:0], i), addrReg, v[20:14]);
      check(modeBit == v[13], $sformatf("R%0d vec%0d mode", v[3:0], i), modeBit, v[13]);
      check(outValid[p] == v[8], $sformatf("R%0d vec%0d valid", v[3:0], i), outValid[p], v[8]);
      if (v[8])
        check(outSel[p*IW +: IW] == v[7:4], $sformatf("R%0d vec%0d sel", v[3:0], i),
              outSel[p*IW +: IW], v[7:4]);
      colCheck();
    end

    // R3 full matrix after full connect
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    sendCmd(4'h1, 7'd6);
    sendCmd(4'h4, 7'd1); sendCmd(4'h4, 7'd2); sendCmd(4'h4, 7'd3);
    sendCmd(4'h1, 7'd7); sendCmd(4'h4, 7'd4);
    sendCmd(4'h1, 7'd8); sendCmd(4'h4, 7'd4);
    sendCmd(4'h1, 7'd6); sendCmd(4'h3, 7'd4);
    check(connMatrix == ((N*N)'(1) << (4*N+6)), "R3 exact matrix", connMatrix,
          (N*N)'(1) << (4*N+6));
    check(addrReg == 7'd7, "R4 addr after full", addrReg, 7);

    // R2 exact matrix after disconnect
    sendCmd(4'h1, 7'd6); sendCmd(4'h4, 7'd5);
    sendCmd(4'h2, 7'd4);
    check(connMatrix == ((N*N)'(1) << (5*N+6)), "R2 exact matrix", connMatrix,
          (N*N)'(1) << (5*N+6));

    // R11 synchronous reset mid-run
    sendCmd(4'h6, 7'd1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(connMatrix == '0, "R11 matrix after rst", connMatrix, '0);
    check(modeBit == 1'b0 && addrReg == 7'd0, "R11 regs after rst",
          {modeBit, addrReg}, 0);
    check(devId == 32'h0000C89F, "R12 id later", devId, 32'h0000C89F);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule